// File: doc/BRIEF.md
# Byte-to-Block Framer for a 128-bit Cipher

This block connects a byte-wide serial receiver and transmitter to a core that works on 128-bit blocks. It collects received bytes into a block register. When sixteen bytes are in, it tells the core with a one-cycle data-ready pulse.

After that it waits for the core to finish. It then loads the result into a transmit shift register and hands the result to the transmitter one byte at a time. Each byte is started with a pulse, and the next byte is offered only when the transmitter reports that the current byte is done. A one-cycle frame-sent pulse marks the end of the last byte.

While a block is with the core or is being sent, the receive path is closed. Any byte that arrives in that time is thrown away and a sticky overrun flag is raised. The reset input is asynchronous and active low. Inside the block, the release of reset is synchronised with two flops.

Top module: `uart_block_framer`

## Requirements
- R1: While reset is held, and after it is released, `blk_ready`, `tx_go`, `frame_sent` and `overrun` are 0 and the block is ready to collect bytes.
- R2: The first byte received in a block is bits [127:120] of `blk_data` and the sixteenth is bits [7:0], so the block is the bytes concatenated in arrival order.
- R3: `blk_ready` is high for exactly one cycle, in the cycle after the clock edge that accepts the sixteenth `rx_tick`.
- R4: The byte count goes back to zero after sixteen bytes, so each block holds only its own sixteen bytes.
- R5: One cycle after `ct_done` is accepted while waiting for the core, `tx_go` pulses for one cycle and `tx_byte` carries bits [127:120] of `ct_data`.
- R6: Each `tx_byte_done` during transmission, other than the sixteenth, causes a one-cycle `tx_go` in the next cycle with the next lower byte on `tx_byte`.
- R7: One cycle after the sixteenth `tx_byte_done`, `frame_sent` pulses for one cycle, no `tx_go` is raised, and the block returns to collecting.
- R8: A `rx_tick` that arrives while waiting for the core or while transmitting is dropped. It sets `overrun`, which stays at 1 until reset, and the dropped byte does not appear in any later block.
- R9: A `ct_done` that arrives while collecting bytes is ignored and does not start a transmission.
- R10: A `tx_byte_done` that arrives while not transmitting is ignored and raises neither `tx_go` nor `frame_sent`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Byte from the receiver |
| rx_tick | input | 1 | One-cycle strobe: `rx_byte` is valid |
| blk_data | output | 128 | Assembled block for the core |
| blk_ready | output | 1 | One-cycle pulse: a full block is ready |
| ct_data | input | 128 | Result block from the core |
| ct_done | input | 1 | One-cycle strobe: `ct_data` is valid |
| tx_byte | output | 8 | Byte for the transmitter |
| tx_go | output | 1 | One-cycle pulse: start sending `tx_byte` |
| tx_byte_done | input | 1 | Strobe: the transmitter finished a byte |
| frame_sent | output | 1 | One-cycle pulse: the last byte has gone out |
| overrun | output | 1 | Sticky flag: a byte was dropped |

## Verification
Every result is registered once, so `blk_ready`, `tx_go` and `frame_sent` are all due exactly one cycle after the strobe that triggers them, and `overrun` rises one cycle after a dropped tick. The bench drives strobes at the falling edge and samples at the falling edge that follows the next rising edge. It checks each pulse in that cycle, and checks in the cycle after that the pulse has dropped. Expected blocks and transmit bytes wait in queues, filled by the driver and by the core stub, and they are popped at the cycle each output is due.

// File: rtl/framer_pkg.sv
package framer_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_CIPHER  = 2'd1,
    ST_SEND    = 2'd2
  } framer_state_e;
endpackage

// File: rtl/framer_rst_sync.sv
module framer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/framer_rx_assembler.sv
module framer_rx_assembler #(
  parameter int BYTE_W    = 8,
  parameter int BLK_BYTES = 16,
  localparam int BLK_W    = BYTE_W * BLK_BYTES,
  localparam int CNT_W    = $clog2(BLK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BLK_W-1:0]  blk,
  output logic              last
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BLK_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BLK_W-1:0] buf_q, buf_d;

  assign last = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    buf_d = buf_q;
    if (take) begin
      buf_d = {buf_q[BLK_W-BYTE_W-1:0], byte_in};
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_d;
      buf_q <= buf_d;
    end
  end

  assign blk = buf_q;

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(buf_q));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |=> (cnt_q == '0));
endmodule

// File: rtl/framer_tx_serializer.sv
module framer_tx_serializer #(
  parameter int BYTE_W    = 8,
  parameter int BLK_BYTES = 16,
  localparam int BLK_W    = BYTE_W * BLK_BYTES,
  localparam int IDX_W    = $clog2(BLK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BLK_W-1:0]  load_data,
  input  logic              advance,
  output logic [BYTE_W-1:0] byte_out,
  output logic              last
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(BLK_BYTES - 1);

  logic [BLK_W-1:0] sr_q, sr_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    sr_d  = sr_q;
    idx_d = idx_q;
    if (load) begin
      sr_d  = load_data;
      idx_d = '0;
    end else if (advance) begin
      sr_d  = {sr_q[BLK_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load || advance) begin
      sr_q  <= sr_d;
      idx_q <= idx_d;
    end
  end

  assign byte_out = sr_q[BLK_W-1 -: BYTE_W];
  assign last     = (idx_q == IDX_MAX);

  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (idx_q != IDX_MAX));
  assert_shift_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(sr_q));
endmodule

// File: rtl/uart_block_framer.sv
module uart_block_framer
  import framer_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int BLK_BYTES = 16,
  localparam int BLK_W    = BYTE_W * BLK_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_tick,
  output logic [BLK_W-1:0]  blk_data,
  output logic              blk_ready,
  input  logic [BLK_W-1:0]  ct_data,
  input  logic              ct_done,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_go,
  input  logic              tx_byte_done,
  output logic              frame_sent,
  output logic              overrun
);
  logic rst_sync_n;
  framer_state_e state_q, state_d;
  logic rx_take, rx_last, tx_adv, tx_last, tx_load;
  logic blk_ready_q, tx_go_q, frame_sent_q, overrun_q;
  logic blk_ready_d, tx_go_d, frame_sent_d, overrun_d;

  framer_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign rx_take = rx_tick && (state_q == ST_COLLECT);
  assign tx_load = ct_done && (state_q == ST_CIPHER);
  assign tx_adv  = tx_byte_done && (state_q == ST_SEND);

  framer_rx_assembler #(.BYTE_W(BYTE_W), .BLK_BYTES(BLK_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .take(rx_take), .byte_in(rx_byte),
    .blk(blk_data), .last(rx_last));

  framer_tx_serializer #(.BYTE_W(BYTE_W), .BLK_BYTES(BLK_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .load(tx_load), .load_data(ct_data),
    .advance(tx_adv && !tx_last), .byte_out(tx_byte), .last(tx_last));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COLLECT: if (rx_take && rx_last) state_d = ST_CIPHER;
      ST_CIPHER:  if (ct_done)            state_d = ST_SEND;
      ST_SEND:    if (tx_adv && tx_last)  state_d = ST_COLLECT;
      default:                            state_d = ST_COLLECT;
    endcase
    blk_ready_d  = rx_take && rx_last;
    tx_go_d      = tx_load || (tx_adv && !tx_last);
    frame_sent_d = tx_adv && tx_last;
    overrun_d    = overrun_q || (rx_tick && (state_q != ST_COLLECT));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q      <= ST_COLLECT;
      blk_ready_q  <= 1'b0;
      tx_go_q      <= 1'b0;
      frame_sent_q <= 1'b0;
      overrun_q    <= 1'b0;
    end else begin
      state_q      <= state_d;
      blk_ready_q  <= blk_ready_d;
      tx_go_q      <= tx_go_d;
      frame_sent_q <= frame_sent_d;
      overrun_q    <= overrun_d;
    end
  end

  assign blk_ready  = blk_ready_q;
  assign tx_go      = tx_go_q;
  assign frame_sent = frame_sent_q;
  assign overrun    = overrun_q;

  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    blk_ready |=> !blk_ready);
  assert_ready_waits_core_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    blk_ready |-> (state_q == ST_CIPHER));
  assert_go_in_send_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_go |-> (state_q == ST_SEND));
  assert_go_pulse_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_go |=> !tx_go);
  assert_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_sent |-> ((state_q == ST_COLLECT) && !tx_go));
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    overrun |=> overrun);
  assert_drop_flags_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_tick && (state_q != ST_COLLECT)) |=> overrun);
  assert_core_ignored_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ct_done && (state_q == ST_COLLECT)) |=> !tx_go);
  assert_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_byte_done && (state_q != ST_SEND)) |=> (!tx_go && !frame_sent));
endmodule

// File: tb/uart_block_framer_tb_top.sv
module uart_block_framer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic [7:0]   rx_byte = '0;
  logic         rx_tick = 1'b0;
  logic [127:0] blk_data;
  logic         blk_ready;
  logic [127:0] ct_data = '0;
  logic         ct_done = 1'b0;
  logic [7:0]   tx_byte;
  logic         tx_go;
  logic         tx_byte_done = 1'b0;
  logic         frame_sent;
  logic         overrun;

  int n_tests = 0;
  int n_fail  = 0;
  int frames  = 0;
  int tx_cnt  = 0;
  bit all_done = 1'b0;
  logic [127:0] exp_blk_q[$];
  logic [7:0]   exp_tx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_block_framer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_tick(rx_tick),
    .blk_data(blk_data), .blk_ready(blk_ready), .ct_data(ct_data),
    .ct_done(ct_done), .tx_byte(tx_byte), .tx_go(tx_go),
    .tx_byte_done(tx_byte_done), .frame_sent(frame_sent), .overrun(overrun));

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b;
    rx_tick = 1'b1;
    @(negedge clk);
    rx_tick = 1'b0;
  endtask

  // Sends one 16-byte block and pushes its expected value (R2: first byte is MSB)
  task automatic send_block(input int seed);
    logic [127:0] e = '0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b = 8'(seed * 13 + i * 29 + 7);
      e = {e[119:0], b};
      if (i == 15) exp_blk_q.push_back(e);
      rx_send(b);
    end
    check("R3 ready pulse after 16th byte", 128'(blk_ready), 128'(1));
    @(negedge clk);
    check("R3 ready lasts one cycle", 128'(blk_ready), 128'(0));
  endtask

  task automatic core_stub();
    while (!all_done) begin
      @(negedge clk);
      if (blk_ready) begin
        logic [127:0] cap = blk_data;
        logic [127:0] e = exp_blk_q.size() > 0 ? exp_blk_q.pop_front() : '1;
        check("R2 R4 block content", cap, e);
        repeat (3) @(negedge clk);
        ct_data = ~cap;
        ct_done = 1'b1;
        for (int k = 0; k < 16; k++) exp_tx_q.push_back(ct_data[127-8*k -: 8]);
        @(negedge clk);
        ct_done = 1'b0;
        check("R5 tx_go after core done", 128'(tx_go), 128'(1));
      end
    end
  endtask

  task automatic uart_stub();
    bit seen;
    while (!all_done) begin
      @(negedge clk);
      seen = tx_go;
      while (seen) begin
        logic [7:0] e = exp_tx_q.size() > 0 ? exp_tx_q.pop_front() : 8'hxx;
        check("R5 R6 tx byte order", 128'(tx_byte), 128'(e));
        repeat (2) @(negedge clk);
        check("R5 tx_go one cycle", 128'(tx_go), 128'(0));
        tx_byte_done = 1'b1;
        @(negedge clk);
        tx_byte_done = 1'b0;
        tx_cnt++;
        if (tx_cnt % 16 == 0) begin
          check("R7 frame_sent", 128'(frame_sent), 128'(1));
          check("R7 no tx_go at end", 128'(tx_go), 128'(0));
          @(negedge clk);
          check("R7 frame_sent one cycle", 128'(frame_sent), 128'(0));
          frames++;
          seen = 1'b0;
        end else begin
          check("R6 next tx_go", 128'(tx_go), 128'(1));
          seen = tx_go;
        end
      end
    end
  endtask

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset ready", 128'(blk_ready), 128'(0));
    check("R1 reset tx_go", 128'(tx_go), 128'(0));
    check("R1 reset frame_sent", 128'(frame_sent), 128'(0));
    check("R1 reset overrun", 128'(overrun), 128'(0));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release", 128'({blk_ready, tx_go, frame_sent, overrun}), 128'(0));

    ct_data = {16{8'hA5}};
    ct_done = 1'b1;
    @(negedge clk);
    ct_done = 1'b0;
    check("R9 core done ignored while collecting", 128'(tx_go), 128'(0));
    @(negedge clk);
    check("R9 still no tx_go", 128'(tx_go), 128'(0));

    tx_byte_done = 1'b1;
    @(negedge clk);
    tx_byte_done = 1'b0;
    check("R10 byte done ignored", 128'({tx_go, frame_sent}), 128'(0));

    fork
      core_stub();
      uart_stub();
      begin
        send_block(1);
        // bytes during core work and transmit are dropped (R8)
        for (int j = 0; j < 8; j++) rx_send(8'hEE);
        check("R8 overrun set", 128'(overrun), 128'(1));
        wait (frames == 1);
        check("R8 overrun sticky", 128'(overrun), 128'(1));
        send_block(2);
        wait (frames == 2);
        send_block(3);
        wait (frames == 3);
        check("R8 overrun still set", 128'(overrun), 128'(1));
        check("R4 all blocks consumed", 128'(exp_blk_q.size()), 128'(0));
        repeat (4) @(negedge clk);
        all_done = 1'b1;
      end
    join
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule